// File: doc/BRIEF.md
# Tick Timer With Match Modes

This block is a 32-bit cycle counter paired with a control word. The control word holds a 28-bit period, an interrupt-enable bit, a sticky pending bit and a 2-bit mode field. On every cycle where the clock enable is high, the low 28 bits of the counter are compared with the period. What a hit does depends on the mode. The counter can be frozen, cleared and restarted, stopped for good, or left running. When interrupts are enabled and nothing is pending yet, a hit also sets the pending bit. The pending bit drives the interrupt output directly.

Software reaches both registers through a single write port and a single read port. Select 0 addresses the counter and select 1 addresses the control word. Either register can be written at any time, and a write always takes priority over what the hardware would have done in that cycle. A small controller runs five named states:

- `ST_IDLE` (timer off)
- `ST_RELOAD` (counts, then clears on a hit)
- `ST_ARMED` (one-shot, counting towards its hit)
- `ST_HALTED` (one-shot after its hit, counter stopped)
- `ST_FREE` (counts through hits)

Each write of the control word moves the controller to the state that the written mode selects. The only transition the hardware makes on its own is `ST_ARMED` to `ST_HALTED`, which happens on a hit.

Top module: `tick_timer`

## Requirements
- R1: After reset, the counter reads 0, the control word reads 0 and the interrupt output is low.
- R2: The control word layout is period in bits 27:0, pending in bit 28, interrupt enable in bit 29 and mode in bits 31:30. Mode 00 is off, and in that mode the counter does not change unless software writes it.
- R3: In mode 01 (auto-restart), the counter increments each enabled cycle. On a hit it becomes 0 after that clock edge, and counting then resumes.
- R4: In mode 10 (one-shot), the counter increments until a hit and then holds its value. It stays stopped, even across counter writes, until the control word is written again.
- R5: In mode 11 (continuous), a hit leaves the counter untouched and it keeps incrementing by one each enabled cycle.
- R6: A hit compares only the counter's low 28 bits with the period. Counting from 0x0FFFFFFF to 0x10000000 therefore hits a period of 0.
- R7: A hit in a cycle with interrupt enable set and pending clear sets the pending bit, and the interrupt output rises after that edge. With interrupt enable clear, a hit leaves the interrupt output low.
- R8: The pending bit is sticky. Only a control-word write with bit 28 at 0 clears it, and the interrupt output falls after that write's edge.
- R9: In mode 00, if the counter already equals the period while interrupt enable is set and pending is clear, the interrupt is raised.
- R10: A counter write takes effect at the next edge in any state, overriding increment and clear. The next hit is evaluated against the written value.
- R11: While the clock enable is low, the counter does not move and no hit is evaluated.
- R12: A control-word write in a cycle that would also set the pending bit leaves pending at the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock enable for counting and hit evaluation |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 counter, 1 control word |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Tick interrupt, equal to the pending bit |

## Verification
The bench targets the following corner cases:

- **Counter wrap into bit 28.** A design that compared all 32 counter bits would miss the hit at 0x10000000.
- **Counter write into a halted one-shot.** A design that restarted counting on the write would show the counter moving past the written value.
- **Control write during a would-be hit.** This only happens with the clock enable held low beforehand. A design that let the hardware set win would raise the interrupt one cycle early.
- **Hit that already exists when the timer is off.** A design that only looked for hits on counter increments would never raise the interrupt here.
- **Enable-off one-shot run.** A design that ignored interrupt enable would raise the interrupt on this run.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_RELOAD = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_FREE   = 2'b11
    } tt_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RELOAD = 3'd1,
        ST_ARMED  = 3'd2,
        ST_HALTED = 3'd3,
        ST_FREE   = 3'd4
    } tt_state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_LOAD  = 2'd3
    } tt_cnt_op_e;

    function automatic tt_state_e mode_entry(input tt_mode_e m);
        tt_state_e s;
        unique case (m)
            MODE_OFF:    s = ST_IDLE;
            MODE_RELOAD: s = ST_RELOAD;
            MODE_SINGLE: s = ST_ARMED;
            MODE_FREE:   s = ST_FREE;
            default:     s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tt_compare.sv
module tt_compare #(
    parameter int CNT_W = 32,
    parameter int PER_W = 28
) (
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [PER_W-1:0] period,
    output logic             hit
);
    logic [PER_W-1:0] cnt_low;

    assign cnt_low = cnt[PER_W-1:0];
    assign hit     = tick_en && (cnt_low == period);

endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tt_cnt_op_e       op,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        unique case (op)
            OP_HOLD:  cnt_d = cnt_q;
            OP_INC:   cnt_d = cnt_q + ONE;
            OP_CLEAR: cnt_d = '0;
            OP_LOAD:  cnt_d = load_val;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
    import tt_pkg::*;
#(
    parameter int PER_W  = 28,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              hit,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] wr_data,
    output tt_state_e         state,
    output tt_cnt_op_e        run_op,
    output logic [PER_W-1:0]  period,
    output logic [DATA_W-1:0] mode_word,
    output logic              pend
);
    localparam int PEND_BIT = PER_W;
    localparam int IE_BIT   = PER_W + 1;
    localparam int MODE_LO  = PER_W + 2;

    tt_state_e        state_q, state_d;
    logic [PER_W-1:0] period_q;
    tt_mode_e         mode_q;
    logic             ie_q;
    logic             pend_q, pend_d;
    tt_mode_e         wr_mode;

    assign wr_mode = tt_mode_e'(wr_data[MODE_LO +: 2]);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = mode_entry(wr_mode);
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_RELOAD: state_d = ST_RELOAD;
                ST_ARMED:  state_d = hit ? ST_HALTED : ST_ARMED;
                ST_HALTED: state_d = ST_HALTED;
                ST_FREE:   state_d = ST_FREE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs: counter operation per state
    always_comb begin
        run_op = OP_HOLD;
        unique case (state_q)
            ST_IDLE:   run_op = OP_HOLD;
            ST_RELOAD: run_op = !tick_en ? OP_HOLD : (hit ? OP_CLEAR : OP_INC);
            ST_ARMED:  run_op = (!tick_en || hit) ? OP_HOLD : OP_INC;
            ST_HALTED: run_op = OP_HOLD;
            ST_FREE:   run_op = tick_en ? OP_INC : OP_HOLD;
            default:   run_op = OP_HOLD;
        endcase
    end

    // control word fields
    always_comb begin
        if (mode_wr) pend_d = wr_data[PEND_BIT];
        else         pend_d = pend_q | (hit & ie_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            mode_q   <= MODE_OFF;
            ie_q     <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            pend_q <= pend_d;
            if (mode_wr) begin
                period_q <= wr_data[PER_W-1:0];
                mode_q   <= wr_mode;
                ie_q     <= wr_data[IE_BIT];
            end
        end
    end

    assign state     = state_q;
    assign period    = period_q;
    assign pend      = pend_q;
    assign mode_word = {mode_q, ie_q, pend_q, period_q};

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PER_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int CNT_W = DATA_W;

    logic              cnt_wr;
    logic              mode_wr;
    logic              hit;
    logic [CNT_W-1:0]  cnt;
    logic [PER_W-1:0]  period;
    logic [DATA_W-1:0] mode_word;
    logic              pend;
    tt_state_e         state;
    tt_cnt_op_e        run_op;
    tt_cnt_op_e        cnt_op;

    assign cnt_wr  = wr_en && !wr_sel;
    assign mode_wr = wr_en && wr_sel;
    assign cnt_op  = cnt_wr ? OP_LOAD : run_op;

    tt_compare #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
        .tick_en (tick_en),
        .cnt     (cnt),
        .period  (period),
        .hit     (hit)
    );

    tt_ctrl #(.PER_W(PER_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .hit       (hit),
        .mode_wr   (mode_wr),
        .wr_data   (wr_data),
        .state     (state),
        .run_op    (run_op),
        .period    (period),
        .mode_word (mode_word),
        .pend      (pend)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (cnt_op),
        .load_val (wr_data),
        .cnt      (cnt)
    );

    assign rd_data = rd_sel ? mode_word : cnt;
    assign irq     = pend;

endmodule

// File: rtl/tt_checker.sv
module tt_checker
    import tt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PER_W  = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] mode_word,
    input tt_state_e         state,
    input logic              irq
);
    logic cnt_wr, mode_wr, ie, match;

    assign cnt_wr  = wr_en && !wr_sel;
    assign mode_wr = wr_en && wr_sel;
    assign ie      = mode_word[PER_W+1];
    assign match   = cnt[PER_W-1:0] == mode_word[PER_W-1:0];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0 && mode_word == '0 && !irq));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !mode_wr && !cnt_wr) |=> $stable(cnt));

    assert_reload_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELOAD && tick_en && match && !cnt_wr) |=> cnt == '0);

    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED && !cnt_wr) |=> $stable(cnt));

    assert_free_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREE && tick_en && !cnt_wr) |=> cnt == $past(cnt) + 1'b1);

    assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && match && ie && !mode_wr) |=> irq);

    assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mode_wr) |=> irq);

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(wr_data));

    assert_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_wr) |=> $stable(cnt));

    assert_wr_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> irq == $past(wr_data[PER_W]));

endmodule

bind tick_timer tt_checker #(.DATA_W(DATA_W), .PER_W(PER_W)) u_tt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cnt       (cnt),
    .mode_word (mode_word),
    .state     (state),
    .irq       (irq)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int          kind;   // 0 counter, 1 control word, 2 irq
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sbq[$];

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] cw(input logic [1:0] m, input logic ie,
                                       input logic ip, input logic [27:0] per);
        return {m, ie, ip, per};
    endfunction

    // driver-side helpers: expectations describe state after the next edge
    task automatic exp_cnt(input logic [31:0] v, input string r);
        exp_t e; e.kind = 0; e.val = v; e.req = r; sbq.push_back(e);
    endtask
    task automatic exp_cw(input logic [31:0] v, input string r);
        exp_t e; e.kind = 1; e.val = v; e.req = r; sbq.push_back(e);
    endtask
    task automatic exp_irq(input logic v, input string r);
        exp_t e; e.kind = 2; e.val = {31'd0, v}; e.req = r; sbq.push_back(e);
    endtask
    task automatic step();
        @(negedge clk);
        wr_en = 1'b0;
    endtask
    task automatic put_cnt(input logic [31:0] v);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = v;
    endtask
    task automatic put_cw(input logic [31:0] v);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = v;
    endtask

    // monitor: pops expectations after each edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0) begin
                exp_t e;
                logic [31:0] got;
                e = sbq.pop_front();
                if (e.kind == 2) begin
                    got = {31'd0, irq};
                end else begin
                    rd_sel = (e.kind == 1);
                    #1;
                    got = rd_data;
                end
                n_checks++;
                if (got !== e.val) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             e.req, e.kind, got, e.val);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt(0, "R1"); exp_cw(0, "R1"); exp_irq(0, "R1");
        step();

        // R10 load, R2 off mode holds
        put_cnt(5); exp_cnt(5, "R10"); step();
        exp_cnt(5, "R2"); step();

        // R9 existing hit in off mode
        put_cw(cw(2'b00, 1, 0, 5)); exp_cw(cw(2'b00, 1, 0, 5), "R2"); exp_irq(0, "R9"); step();
        exp_irq(1, "R9"); step();
        exp_cw(cw(2'b00, 1, 1, 5), "R8"); exp_irq(1, "R8"); step();
        put_cw(cw(2'b00, 0, 0, 5)); exp_irq(0, "R8"); step();
        exp_irq(0, "R7"); exp_cnt(5, "R2"); step();

        // R3 auto-restart with period 3
        put_cnt(0); step();
        put_cw(cw(2'b01, 1, 0, 3)); exp_cnt(0, "R3"); step();
        exp_cnt(1, "R3"); step();
        exp_cnt(2, "R3"); step();
        exp_cnt(3, "R3"); exp_irq(0, "R7"); step();
        exp_cnt(0, "R3"); exp_irq(1, "R7"); step();
        exp_cnt(1, "R3"); step();

        // R4 one-shot with period 2
        put_cw(cw(2'b00, 0, 0, 0)); step();
        put_cnt(0); step();
        put_cw(cw(2'b10, 1, 0, 2)); exp_cnt(0, "R4"); step();
        exp_cnt(1, "R4"); step();
        exp_cnt(2, "R4"); exp_irq(0, "R4"); step();
        exp_cnt(2, "R4"); exp_irq(1, "R7"); step();
        exp_cnt(2, "R4"); step();
        put_cnt(0); exp_cnt(0, "R10"); step();
        exp_cnt(0, "R4"); step();
        put_cw(cw(2'b10, 0, 0, 2)); exp_cnt(0, "R4"); exp_irq(0, "R8"); step();
        exp_cnt(1, "R4"); step();
        exp_cnt(2, "R4"); step();
        exp_cnt(2, "R4"); exp_irq(0, "R7"); step();

        // R5/R6 continuous across the 28-bit wrap, period 0
        put_cw(cw(2'b00, 0, 0, 0)); step();
        put_cnt(32'h0FFF_FFFE); step();
        put_cw(cw(2'b11, 1, 0, 0)); exp_cnt(32'h0FFF_FFFE, "R5"); step();
        exp_cnt(32'h0FFF_FFFF, "R5"); step();
        exp_cnt(32'h1000_0000, "R6"); exp_irq(0, "R6"); step();
        exp_cnt(32'h1000_0001, "R5"); exp_irq(1, "R6"); step();
        exp_cnt(32'h1000_0002, "R5"); step();

        // R11 enable low, R12 write wins over hit
        put_cw(cw(2'b00, 0, 0, 0)); step();
        tick_en = 1'b0;
        put_cnt(7); exp_cnt(7, "R10"); step();
        put_cw(cw(2'b00, 1, 0, 7)); step();
        exp_irq(0, "R11"); exp_cnt(7, "R11"); step();
        tick_en = 1'b1;
        put_cw(cw(2'b00, 1, 0, 7)); exp_irq(0, "R12"); step();
        exp_irq(1, "R12"); step();
        tick_en = 1'b0;
        put_cw(cw(2'b11, 0, 0, 0)); exp_cnt(7, "R11"); step();
        exp_cnt(7, "R11"); step();
        tick_en = 1'b1;
        exp_cnt(8, "R5"); step();

        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule